// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog for a processor subsystem. A 16-bit counter counts up from a programmable start value. It advances once per prescaler period, and the prescaler divides the system clock by one of two fixed ratios. Software must service the watchdog before the counter wraps past its all-ones value.

A missed service does not reset the system straight away. The first wrap raises a warning flag that an interrupt handler can see and acknowledge. A second wrap while that flag is still set issues a single-cycle request to the reset controller.

The enable and disable strobes come from instruction decode elsewhere and can stop or restart the watchdog at any time. The start value and the ratio select form the configuration. The configuration can change only while the watchdog is stopped. An attempt to change it while the watchdog runs is refused and leaves a sticky error flag.

Top module: `wdog_prewarn`

## Requirements
- R1: After a synchronous reset the watchdog is running, the start value is 0xFF00, the slow ratio is off, the count output reads 0xFF00, and warn, reset request and error are all low.
- R2: The counter advances once every DIV_LO clocks when `cfg_long_i` was written 0, and once every DIV_HI clocks when it was written 1 (defaults 256 and 16384). From a start or service, the first wrap therefore shows on `warn_o` exactly ratio × (65536 − start value) clocks later.
- R3: A service strobe loads the counter with the start value and clears the prescaler, so the next wrap is timed afresh from the service edge.
- R4: When the counter steps from 0xFFFF, it reloads the start value and `warn_o` goes high.
- R5: A wrap while `warn_o` is already high raises `rst_req_o` for exactly one clock, and `warn_o` stays high.
- R6: A pulse on `warn_clr_i` clears `warn_o`. A service strobe does not clear it.
- R7: While stopped, the counter and the prescaler hold their values and no warning is raised. Counting resumes from the held prescaler phase on enable. When enable and disable arrive together, the watchdog ends up stopped.
- R8: A configuration write while stopped takes effect and leaves `cfg_err_o` low. A write while running changes nothing and sets `cfg_err_o`, which stays high until reset.
- R9: A wrap while `warn_o` is low raises only the warning, with no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_i | input | 1 | Service strobe: reload counter, clear prescaler |
| en_cmd_i | input | 1 | Start strobe |
| dis_cmd_i | input | 1 | Stop strobe (wins over start) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_reload_i | input | 16 | Start value to write |
| cfg_long_i | input | 1 | Ratio select to write: 1 = DIV_HI, 0 = DIV_LO |
| warn_clr_i | input | 1 | Write-one-to-clear for the warning flag |
| cnt_o | output | 16 | Current counter value |
| running_o | output | 1 | Watchdog is counting |
| warn_o | output | 1 | Prewarning interrupt flag |
| rst_req_o | output | 1 | One-cycle reset request |
| cfg_err_o | output | 1 | Sticky refused-write flag |

## Verification
The bench measures the clock count to the first warning for several start values under both ratios. A design that forgets to clear the prescaler on service, or that miscounts the wrap from 0xFFFF, would be off by cycles in these measurements.

It stops the watchdog partway through a prescaler period and expects the wrap one clock after restart. A design that reset the prescaler on stop would need a full period instead.

It also checks three other cases:
- A wrap after the warning was acknowledged must raise no reset request, while a wrap with the warning still standing must give a single-cycle request.
- A configuration write while running must leave the start value unchanged and latch the error flag.
- A service strobe must leave a standing warning in place.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned WDOG_CW = 16;
  typedef logic [WDOG_CW-1:0] wcount_t;
  typedef struct packed {
    logic    long_div;
    wcount_t reload;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_LO = 256,
  parameter int unsigned DIV_HI = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  input  logic long_div,
  output logic tick
);
  localparam int unsigned PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [PW-1:0] LAST_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] last;
  logic          at_end;

  assign last   = long_div ? LAST_HI : LAST_LO;
  assign at_end = (phase >= last);
  assign tick   = run && !clr && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= '0;
    end else if (run) begin
      phase <= at_end ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter wcount_t INIT = 16'hFF00
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    tick,
  input  wcount_t reload,
  output wcount_t cnt,
  output logic    wrap
);
  localparam wcount_t TOP = '1;

  assign wrap = tick && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= INIT;
    end else if (load) begin
      cnt <= reload;
    end else if (tick) begin
      cnt <= wrap ? reload : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter wcount_t INIT_RELOAD = 16'hFF00
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic      running,
  input  wcount_t   wr_reload,
  input  logic      wr_long,
  output wdog_cfg_t cfg,
  output logic      err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.reload   <= INIT_RELOAD;
      cfg.long_div <= 1'b0;
      err          <= 1'b0;
    end else if (we) begin
      if (running) begin
        err <= 1'b1;
      end else begin
        cfg.reload   <= wr_reload;
        cfg.long_div <= wr_long;
      end
    end
  end
endmodule

// File: rtl/wdog_prewarn.sv
module wdog_prewarn
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_LO     = 256,
  parameter int unsigned DIV_HI     = 16384,
  parameter wcount_t     RST_RELOAD = 16'hFF00
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    svc_i,
  input  logic    en_cmd_i,
  input  logic    dis_cmd_i,
  input  logic    cfg_we_i,
  input  wcount_t cfg_reload_i,
  input  logic    cfg_long_i,
  input  logic    warn_clr_i,
  output wcount_t cnt_o,
  output logic    running_o,
  output logic    warn_o,
  output logic    rst_req_o,
  output logic    cfg_err_o
);
  wdog_cfg_t cfg;
  logic      run_q;
  logic      warn_q;
  logic      req_q;
  logic      tick;
  logic      wrap;

  wdog_cfg #(.INIT_RELOAD(RST_RELOAD)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we_i),
    .running  (run_q),
    .wr_reload(cfg_reload_i),
    .wr_long  (cfg_long_i),
    .cfg      (cfg),
    .err      (cfg_err_o)
  );

  wdog_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .clr     (svc_i),
    .long_div(cfg.long_div),
    .tick    (tick)
  );

  wdog_counter #(.INIT(RST_RELOAD)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .load  (svc_i),
    .tick  (tick),
    .reload(cfg.reload),
    .cnt   (cnt_o),
    .wrap  (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      warn_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (dis_cmd_i)     run_q <= 1'b0;
      else if (en_cmd_i) run_q <= 1'b1;
      if (wrap)            warn_q <= 1'b1;
      else if (warn_clr_i) warn_q <= 1'b0;
      req_q <= wrap && warn_q;
    end
  end

  assign running_o = run_q;
  assign warn_o    = warn_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_prewarn_chk.sv
module wdog_prewarn_chk
  import wdog_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    svc_i,
  input logic    cfg_we_i,
  input wcount_t cnt_o,
  input logic    running_o,
  input logic    warn_o,
  input logic    rst_req_o,
  input logic    cfg_err_o
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (running_o && !warn_o && !rst_req_o && !cfg_err_o));

  assert_warn_from_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_o) |-> ($past(cnt_o) == '1 && $past(running_o)));

  assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  assert_req_keeps_warn_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> warn_o);

  assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !svc_i) |=> $stable(cnt_o));

  assert_no_warn_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !warn_o) |=> !warn_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err_o) |-> $past(cfg_we_i && running_o));
endmodule

bind wdog_prewarn wdog_prewarn_chk u_chk (.*);

// File: tb/wdog_prewarn_bench.sv
module wdog_prewarn_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam logic [15:0] V_RELOAD [NV] = '{16'hFFFF, 16'hFFF0, 16'hFFFF, 16'hFFF8, 16'hFF00};
  localparam logic        V_LONG   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_CYC    [NV] = '{4, 64, 16, 128, 1024};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic svc_i = 0, en_cmd_i = 0, dis_cmd_i = 0, cfg_we_i = 0, cfg_long_i = 0, warn_clr_i = 0;
  logic [15:0] cfg_reload_i = '0;
  logic [15:0] cnt_o;
  logic running_o, warn_o, rst_req_o, cfg_err_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_prewarn #(.DIV_LO(4), .DIV_HI(16)) u_wdog_prewarn (
    .clk(clk), .rst(rst), .svc_i(svc_i), .en_cmd_i(en_cmd_i), .dis_cmd_i(dis_cmd_i),
    .cfg_we_i(cfg_we_i), .cfg_reload_i(cfg_reload_i), .cfg_long_i(cfg_long_i),
    .warn_clr_i(warn_clr_i), .cnt_o(cnt_o), .running_o(running_o), .warn_o(warn_o),
    .rst_req_o(rst_req_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic s, input logic e, input logic d, input logic c);
    svc_i = s; en_cmd_i = e; dis_cmd_i = d; warn_clr_i = c;
    cyc();
    svc_i = 0; en_cmd_i = 0; dis_cmd_i = 0; warn_clr_i = 0;
  endtask

  task automatic write_cfg(input logic [15:0] rl, input logic lg);
    cfg_we_i = 1; cfg_reload_i = rl; cfg_long_i = lg;
    cyc();
    cfg_we_i = 0;
  endtask

  task automatic wait_warn(output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!warn_o && n < 5000);
  endtask

  initial begin
    int n;
    logic [15:0] held;
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    // R1 reset state
    chk("R1 cnt", cnt_o, 16'hFF00);
    chk("R1 running", running_o, 1);
    chk("R1 warn", warn_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 err", cfg_err_o, 0);
    // R2/R4 default interval, R5 second wrap
    wait_warn(n);
    chk("R2 default interval", n, 1024);
    chk("R4 reload on wrap", cnt_o, 16'hFF00);
    n = 0;
    do begin cyc(); n++; end while (!rst_req_o && n < 5000);
    chk("R5 second wrap timing", n, 1024);
    chk("R5 warn kept", warn_o, 1);
    cyc();
    chk("R5 one-cycle pulse", rst_req_o, 0);
    // table walk: R2, R3, R8
    for (int i = 0; i < NV; i++) begin
      strobe(0, 0, 1, 0);
      write_cfg(V_RELOAD[i], V_LONG[i]);
      chk("R8 no error when stopped", cfg_err_o, 0);
      strobe(1, 1, 0, 1);
      chk("R3 service loads start", cnt_o, V_RELOAD[i]);
      chk("R6 cleared", warn_o, 0);
      wait_warn(n);
      chk("R2 interval table", n, V_CYC[i]);
    end
    // R8 refused write while running
    write_cfg(16'h1234, 1'b1);
    chk("R8 error set", cfg_err_o, 1);
    strobe(1, 0, 0, 0);
    chk("R8 start value unchanged", cnt_o, 16'hFF00);
    chk("R6 service keeps warn", warn_o, 1);
    strobe(0, 0, 0, 1);
    chk("R6 clear", warn_o, 0);
    // R7 hold while stopped
    repeat (5) cyc();
    strobe(0, 0, 1, 0);
    held = cnt_o;
    repeat (50) cyc();
    chk("R7 count held", cnt_o, held);
    chk("R7 stopped", running_o, 0);
    chk("R7 no warn", warn_o, 0);
    strobe(0, 1, 1, 0);
    chk("R7 disable wins", running_o, 0);
    // R9 then R5
    write_cfg(16'hFFFF, 1'b0);
    chk("R8 error sticky", cfg_err_o, 1);
    strobe(1, 1, 0, 1);
    wait_warn(n);
    chk("R2 shortest interval", n, 4);
    strobe(0, 0, 0, 1);
    chk("R6 clear", warn_o, 0);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R9 no request", rst_req_o, 0);
    end
    chk("R9 warn again", warn_o, 1);
    repeat (4) cyc();
    chk("R5 request after warn", rst_req_o, 1);
    // R7 prescaler phase held
    strobe(0, 0, 1, 0);
    strobe(1, 0, 0, 1);
    strobe(0, 1, 0, 0);
    cyc();
    cyc();
    strobe(0, 0, 1, 0);
    repeat (10) cyc();
    chk("R7 no warn stopped", warn_o, 0);
    strobe(0, 1, 0, 0);
    chk("R7 restarted", running_o, 1);
    wait_warn(n);
    chk("R7 phase held", n, 1);
    strobe(0, 1, 1, 0);
    chk("R7 disable wins running", running_o, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule